// File: doc/BRIEF.md
# Sign-Driven Up/Down Tally Engine with Writeback

This block is a small controller-plus-datapath engine. It walks a fixed-length window of an external read/write memory and keeps a signed running tally. For each word it reads, it decides whether the word is strictly positive. A positive word raises the tally by one. A zero or negative word lowers it by one. The engine then stores the new tally back into the word it just read, so after a run the window holds the tally's history.

A single `start` pulse launches a run over `COUNT` words, beginning at the base address latched with that pulse. The memory and its one-cycle read latency belong to the surrounding system. The two branch outcomes are separate controller states; they are not folded into one datapath mux. Each element costs five cycles: check bound, issue read, test sign, adjust tally, write back. When the window is finished, `done` rises and the final tally stays on `tally_out` until the next `start`.

Top module: `sign_tally_engine`

## Requirements
- R1: After reset, `done`, `mem_rd` and `mem_wr` are 0 and `tally_out` is 0.
- R2: A `start` pulse clears the tally to 0, latches `base_addr`, and issues exactly `COUNT` (default 100) reads at addresses base+0, base+1, … in ascending order, with one write per read.
- R3: A word whose bit `DATA_W-1` is 0 and which is nonzero counts as positive and raises the tally by exactly 1.
- R4: A word that is zero or has bit `DATA_W-1` set lowers the tally by exactly 1, using two's-complement wrap.
- R5: After each update, the new tally is driven on `mem_wdata` with `mem_wr` high for exactly one cycle, at the address read three cycles earlier.
- R6: Read data is taken the cycle after `mem_rd` is high, and `mem_rd` and `mem_wr` are never high in the same cycle.
- R7: After the last write, `done` goes high and stays high with `tally_out` unchanged until the next `start`. `tally_out` then equals the number of positive words minus the number of non-positive words.
- R8: A `start` given while `done` is high begins a fresh run from a tally of 0 at the newly latched base. Memory words outside the window are never written.
- R9: The address is (base + index) modulo 2^`ADDR_W`, so a window that runs past the top of the address space wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a run (taken in idle or done) |
| base_addr | input | ADDR_W | First address of the window, latched with `start` |
| mem_addr | output | ADDR_W | Memory address for the current read or write |
| mem_rd | output | 1 | Read strobe; data returns one cycle later |
| mem_wr | output | 1 | Write strobe, one cycle per element |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_wdata | output | DATA_W | Write data (the updated tally) |
| tally_out | output | DATA_W | Running and final signed tally |
| done | output | 1 | High from the end of a run until the next `start` |

## Verification
The engine is run over several windows. The first is all positive, which must count up to +100 and never take the decrement state. The second is all zero, which must count down to −100 and shows that zero is not treated as positive. The third alternates the largest positive word with the most negative word, which tests the sign bit and the nonzero test at their extremes and must settle at 0. A mixed 1/−1 pattern and a hashed pseudo-random pattern follow, and one window starts near the top of the address space to force wrap-around. After each run, every written-back word is compared with a reference tally computed in the bench, the words just outside the window must keep their sentinel value, and a port monitor confirms the read order, the single-cycle write strobes and that reads and writes never overlap.

// File: rtl/sign_tally_pkg.sv
package sign_tally_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_READ,
      ST_TEST,
      ST_INC,
      ST_DEC,
      ST_WRITE,
      ST_DONE
   } st_state_e;

endpackage

// File: rtl/st_ctrl.sv
module st_ctrl
   import sign_tally_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic last,
   input  logic positive,
   output logic clear,
   output logic rd,
   output logic inc,
   output logic dec,
   output logic wr,
   output logic step,
   output logic done
);

   st_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      clear   = 1'b0;
      rd      = 1'b0;
      inc     = 1'b0;
      dec     = 1'b0;
      wr      = 1'b0;
      step    = 1'b0;
      done    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               clear   = 1'b1;
               state_d = ST_CHECK;
            end
         end
         ST_CHECK: state_d = last ? ST_DONE : ST_READ;
         ST_READ: begin
            rd      = 1'b1;
            state_d = ST_TEST;
         end
         ST_TEST: state_d = positive ? ST_INC : ST_DEC;
         ST_INC: begin
            inc     = 1'b1;
            state_d = ST_WRITE;
         end
         ST_DEC: begin
            dec     = 1'b1;
            state_d = ST_WRITE;
         end
         ST_WRITE: begin
            wr      = 1'b1;
            step    = 1'b1;
            state_d = ST_CHECK;
         end
         ST_DONE: begin
            done = 1'b1;
            if (start) begin
               clear   = 1'b1;
               state_d = ST_CHECK;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // R3/R4: the two branch states are entered only from the sign test
   assert_branch_from_test_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc || dec) |-> $past(state_q) == ST_TEST);

   // R5: each write follows exactly one tally update
   assert_write_after_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> $past(inc) || $past(dec));

endmodule

// File: rtl/st_index.sv
module st_index #(
   parameter int ADDR_W = 12,
   parameter int COUNT  = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic [ADDR_W-1:0] base_in,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);

   localparam int IDX_W = $clog2(COUNT + 1);

   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
      end else if (clear) begin
         base_q <= base_in;
         idx_q  <= '0;
      end else if (step) begin
         idx_q  <= idx_q + IDX_W'(1);
      end
   end

   generate
      if (IDX_W < ADDR_W) begin : g_widen_idx
         assign addr = base_q + {{(ADDR_W - IDX_W){1'b0}}, idx_q};
      end else begin : g_trim_idx
         assign addr = base_q + idx_q[ADDR_W-1:0];
      end
   endgenerate

   assign last = (idx_q == IDX_W'(COUNT));

   // R2: the index never runs past the window length
   assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IDX_W'(COUNT));

   // R2: the index advances by one per step
   assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step && !clear |=> idx_q == $past(idx_q) + IDX_W'(1));

endmodule

// File: rtl/st_tally.sv
module st_tally #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              inc,
   input  logic              dec,
   input  logic [DATA_W-1:0] rdata,
   output logic              positive,
   output logic [DATA_W-1:0] tally
);

   logic [DATA_W-1:0] tally_q;

   assign positive = ~rdata[DATA_W-1] & (|rdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tally_q <= '0;
      else if (clear) tally_q <= '0;
      else if (inc)   tally_q <= tally_q + DATA_W'(1);
      else if (dec)   tally_q <= tally_q - DATA_W'(1);
   end

   assign tally = tally_q;

   assert_inc_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> tally_q == $past(tally_q) + DATA_W'(1));

   assert_dec_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dec |=> tally_q == $past(tally_q) - DATA_W'(1));

   assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> tally_q == '0);

   assert_no_double_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc && dec));

endmodule

// File: rtl/sign_tally_engine.sv
module sign_tally_engine #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12,
   parameter int COUNT  = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] tally_out,
   output logic              done
);

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W must be at least 2");
      end
      if (COUNT < 1) begin : g_bad_count
         $error("COUNT must be at least 1");
      end
      if (COUNT > (1 << ADDR_W)) begin : g_bad_window
         $error("COUNT must not exceed the address space");
      end
   endgenerate

   logic clear, inc, dec, step, last, positive;

   st_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .last     (last),
      .positive (positive),
      .clear    (clear),
      .rd       (mem_rd),
      .inc      (inc),
      .dec      (dec),
      .wr       (mem_wr),
      .step     (step),
      .done     (done)
   );

   st_index #(.ADDR_W(ADDR_W), .COUNT(COUNT)) u_index (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .step    (step),
      .base_in (base_addr),
      .addr    (mem_addr),
      .last    (last)
   );

   st_tally #(.DATA_W(DATA_W)) u_tally (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .inc      (inc),
      .dec      (dec),
      .rdata    (mem_rdata),
      .positive (positive),
      .tally    (tally_out)
   );

   assign mem_wdata = tally_out;

   assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr);

   assert_wr_same_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(mem_rd, 3) && (mem_addr == $past(mem_addr, 3)));

   assert_rd_wr_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done && $stable(tally_out));

   assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_rd && !mem_wr);

endmodule

// File: tb/sim_sign_tally_engine.sv
module sim_sign_tally_engine;

   localparam int DATA_W = 16;
   localparam int ADDR_W = 10;
   localparam int COUNT  = 100;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam logic [DATA_W-1:0] SENTINEL = 16'h5A5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [ADDR_W-1:0] base_addr = '0;
   logic [ADDR_W-1:0] mem_addr;
   logic mem_rd, mem_wr;
   logic [DATA_W-1:0] mem_rdata, mem_wdata, tally_out;
   logic done;

   always #2 clk = ~clk;   // 250 MHz

   sign_tally_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .COUNT(COUNT)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
      .tally_out(tally_out), .done(done)
   );

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem[mem_addr];
      if (mem_wr) mem[mem_addr] <= mem_wdata;
   end

   int n_checks = 0;
   int n_fail = 0;

   // port monitor
   int rd_cnt, wr_cnt, order_err, overlap_err, wr_addr_err, wr_long_err;
   logic [ADDR_W-1:0] next_rd_addr, last_rd_addr;
   logic wr_prev;

   always @(posedge clk) begin
      if (rst_n) begin
         if (mem_rd) begin
            if (mem_addr != next_rd_addr) order_err++;
            next_rd_addr <= mem_addr + ADDR_W'(1);
            last_rd_addr <= mem_addr;
            rd_cnt++;
         end
         if (mem_wr) begin
            if (mem_addr != last_rd_addr) wr_addr_err++;
            wr_cnt++;
         end
         if (mem_rd && mem_wr) overlap_err++;
         if (mem_wr && wr_prev) wr_long_err++;
         wr_prev <= mem_wr;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] elem(input int pat, input int i);
      logic [31:0] h;
      case (pat)
         0: elem = DATA_W'(i + 1);
         1: elem = '0;
         2: elem = (i % 2 == 0) ? 16'h7FFF : 16'h8000;
         3: elem = (i % 3 == 0) ? 16'h0001 : 16'hFFFF;
         default: begin
            h = 32'(i) * 32'd40503 + 32'd12345;
            h = h ^ (h >> 7);
            elem = (i % 11 == 0) ? '0 : h[DATA_W-1:0];
         end
      endcase
   endfunction

   task automatic run(input int pat, input int base, input string name);
      logic [DATA_W-1:0] expw [COUNT];
      logic [DATA_W-1:0] t;
      logic [DATA_W-1:0] held;
      int wait_cnt;
      for (int a = 0; a < DEPTH; a++) mem[a] = SENTINEL;
      t = '0;
      for (int i = 0; i < COUNT; i++) begin
         logic [DATA_W-1:0] v;
         v = elem(pat, i);
         mem[(base + i) % DEPTH] = v;
         t = ($signed(v) > 0) ? t + DATA_W'(1) : t - DATA_W'(1);
         expw[i] = t;
      end
      @(negedge clk);
      rd_cnt = 0; wr_cnt = 0; order_err = 0; overlap_err = 0;
      wr_addr_err = 0; wr_long_err = 0;
      next_rd_addr = ADDR_W'(base);
      base_addr = ADDR_W'(base);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      base_addr = ~ADDR_W'(base);   // latched value must be used
      chk(!done, {name, " R8 done drops after start"}, longint'(done), 0);
      wait_cnt = 0;
      while (!done && wait_cnt < 2000) begin
         @(negedge clk);
         wait_cnt++;
      end
      chk(done, {name, " R7 done reached (watchdog)"}, longint'(done), 1);
      chk(tally_out == t, {name, " R7 final tally"},
          longint'($signed(tally_out)), longint'($signed(t)));
      for (int i = 0; i < COUNT; i++)
         chk(mem[(base + i) % DEPTH] == expw[i], {name, " R5 written-back word"},
             longint'($signed(mem[(base + i) % DEPTH])), longint'($signed(expw[i])));
      chk(mem[(base + DEPTH - 1) % DEPTH] == SENTINEL, {name, " R8 word below window"},
          longint'(mem[(base + DEPTH - 1) % DEPTH]), longint'(SENTINEL));
      chk(mem[(base + COUNT) % DEPTH] == SENTINEL, {name, " R8 word above window"},
          longint'(mem[(base + COUNT) % DEPTH]), longint'(SENTINEL));
      chk(rd_cnt == COUNT, {name, " R2 read count"}, rd_cnt, COUNT);
      chk(wr_cnt == COUNT, {name, " R2 write count"}, wr_cnt, COUNT);
      chk(order_err == 0, {name, " R9 ascending wrapped read order"}, order_err, 0);
      chk(wr_addr_err == 0, {name, " R5 write at read address"}, wr_addr_err, 0);
      chk(wr_long_err == 0, {name, " R5 one-cycle write strobe"}, wr_long_err, 0);
      chk(overlap_err == 0, {name, " R6 read/write apart"}, overlap_err, 0);
      held = tally_out;
      repeat (6) @(negedge clk);
      chk(done && tally_out == held, {name, " R7 done and tally held"},
          longint'(tally_out), longint'(held));
      chk(!mem_rd && !mem_wr, {name, " R7 memory quiet while done"},
          longint'({mem_rd, mem_wr}), 0);
   endtask

   initial begin
      wr_prev = 1'b0;
      rd_cnt = 0; wr_cnt = 0; order_err = 0; overlap_err = 0;
      wr_addr_err = 0; wr_long_err = 0;
      next_rd_addr = '0; last_rd_addr = '0;
      repeat (3) @(negedge clk);
      chk(!done && !mem_rd && !mem_wr, "R1 strobes low in reset",
          longint'({done, mem_rd, mem_wr}), 0);
      chk(tally_out == '0, "R1 tally zero in reset", longint'(tally_out), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!done && !mem_rd && !mem_wr && tally_out == '0, "R1 idle after reset",
          longint'({done, mem_rd, mem_wr}), 0);
      run(0, 0,   "all-positive R3");          // +100
      run(1, 100, "all-zero R4");              // -100
      run(2, 500, "extremes R3 R4");           // 0
      run(3, 7,   "mixed R3 R4");              // 34 - 66 = -32
      run(4, 1000, "hashed wrap R9");          // window wraps past top
      run(0, 970, "restart R8");               // fresh run from done
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule